// File: doc/BRIEF.md
# Synchronous Burst SRAM Core

This block is a small synchronous static memory that answers four-beat bursts with flow-through reads. An access opens when one of two address strobes is sampled low on a rising clock edge. One strobe serves a processor and the other a cache controller. On that edge the block captures the address and the three chip-select inputs. The read word for the captured address is on the data output in the cycle that follows the edge, with no further register stage. An advance input then moves a two-bit beat counter through the other three words of the aligned four-word block, one word per advancing edge. The access pattern is therefore two cycles for the first word and one cycle for each of the next three.

A static order input chooses how the beats run. In exclusive-or order the low address bits are the start bits combined with the beat count. In wrapping order the beat count is added to the start bits, modulo four. Writes use a global write input, or a byte-write enable combined with one low-active strobe per byte lane. The common data bus is split into separate input and output ports. A valid flag on the output is gated by an output enable that has no register in its path.

Top module: `sbsram_core`

## Requirements
- R1: While reset is held, and after it is released until the first strobe, dout_vld_o is 0 and dout_o is all zeros. Reset clears every memory word to zero.
- R2: A start takes place on an edge where cstb_n_i is 0, or where pstb_n_i is 0 and ce1_n_i is 0. On a start the block captures addr_i and the chip-select decode, and sets the beat count to 0, even if adv_n_i is low on the same edge. On any other edge the captured address and select state are kept.
- R3: A start in the middle of a burst restarts the burst at the new address straight away.
- R4: The beat count increases by one only on edges where adv_n_i is 0 and both strobes are 1. After the fourth beat it wraps back to the first word of the same four-word block. With adv_n_i at 1 and no start, the addressed word stays the same.
- R5: With mode_i = 1, the low two address bits of beat k (k = 0..3) are the start bits XOR k. The upper address bits do not change.
- R6: With mode_i = 0, the low two address bits of beat k are (start bits + k) mod 4. The upper address bits do not change.
- R7: Reads are flow-through. After an edge that is not a write, dout_o holds the word at the current beat address during the following cycle. dout_vld_o is 1 when the device is selected, oe_n_i is 0 and the last edge did not write.
- R8: oe_n_i = 1 forces dout_vld_o to 0 and dout_o to zero at once, with no clock edge needed. Returning it to 0 restores the data in the same cycle.
- R9: The device is selected only when, at the start edge, ce1_n_i = 0, ce2_i = 1 and ce3_n_i = 0.
- R10: A processor-strobe start with ce1_n_i = 1 is ignored, and the captured address is kept. A processor-strobe start is always a read: write controls on that edge change no memory.
- R11: A write happens on an edge with gw_n_i = 0 (all bytes), or with bwe_n_i = 0 (only the bytes whose bw_n_i bit is 0). Byte i is din_i[8i+7:8i]. The target is the beat address that results from that edge. With bwe_n_i = 1 and gw_n_i = 1, the bw_n_i inputs have no effect.
- R12: While the device is deselected, writes do not change the memory, dout_vld_o is 0 and dout_o is zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| addr_i | input | ADDR_W | Word address, captured on a start |
| din_i | input | BYTES*BYTE_W | Write data |
| dout_o | output | BYTES*BYTE_W | Flow-through read data, zero when not valid |
| dout_vld_o | output | 1 | Read data valid |
| oe_n_i | input | 1 | Output enable, low active, not registered |
| ce1_n_i | input | 1 | Chip select, low active; also qualifies the processor strobe |
| ce2_i | input | 1 | Chip select, high active |
| ce3_n_i | input | 1 | Chip select, low active |
| pstb_n_i | input | 1 | Processor address strobe, low active |
| cstb_n_i | input | 1 | Controller address strobe, low active |
| adv_n_i | input | 1 | Burst advance, low active |
| gw_n_i | input | 1 | Global write, low active |
| bwe_n_i | input | 1 | Byte-write enable, low active |
| bw_n_i | input | BYTES | Per-byte write strobes, low active |
| mode_i | input | 1 | Beat order: 1 exclusive-or, 0 wrapping |

## Verification
Two functions can fall on one edge. The first case is a strobe and an advance together, where the reload must win and the counter must not also step. The second is a processor-strobe start together with active write controls, where the read must win and memory must stay as it was. Both cases are driven on purpose in the directed part of the bench and come up again often in a long random phase. A behavioural model keeps its own base, beat count, select flag and memory image. It is compared with the data output and the valid flag one cycle after each edge, so any wrong address step, extra write or lost reload shows up on the next read.

// File: rtl/sbsram_pkg.sv
package sbsram_pkg;

    localparam int unsigned BEAT_W    = 2;
    localparam int unsigned BURST_LEN = 1 << BEAT_W;

    typedef logic [BEAT_W-1:0] beat_t;

    typedef enum logic {
        ORDER_WRAP = 1'b0,
        ORDER_XOR  = 1'b1
    } beat_order_e;

    typedef struct packed {
        logic start;   // any accepted strobe
        logic pstart;  // start taken by processor strobe
        logic step;    // advance the beat count
        logic sel;     // chip-select decode on this edge
    } strobe_dec_t;

    function automatic beat_t beat_low(beat_t first, beat_t count, beat_order_e order);
        beat_t r;
        if (order == ORDER_XOR) r = first ^ count;
        else                    r = beat_t'(first + count);
        return r;
    endfunction

endpackage

// File: rtl/sbsram_ctl.sv
module sbsram_ctl
    import sbsram_pkg::*;
#(
    parameter int BYTES = 2
) (
    input  logic             pstb_n,
    input  logic             cstb_n,
    input  logic             adv_n,
    input  logic             ce1_n,
    input  logic             ce2,
    input  logic             ce3_n,
    input  logic             gw_n,
    input  logic             bwe_n,
    input  logic [BYTES-1:0] bw_n,
    output strobe_dec_t      dec,
    output logic [BYTES-1:0] wmask
);

    logic pstart;
    logic any_strobe;

    assign pstart     = ~pstb_n & ~ce1_n;
    assign any_strobe = ~pstb_n | ~cstb_n;

    always_comb begin
        dec.pstart = pstart;
        dec.start  = pstart | ~cstb_n;
        dec.step   = ~any_strobe & ~adv_n;
        dec.sel    = ~ce1_n & ce2 & ~ce3_n;
    end

    // a processor-strobe start is always a read
    for (genvar g = 0; g < BYTES; g++) begin : g_lane_en
        assign wmask[g] = ~pstart & (~gw_n | (~bwe_n & ~bw_n[g]));
    end

endmodule

// File: rtl/sbsram_burst.sv
module sbsram_burst
    import sbsram_pkg::*;
#(
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  strobe_dec_t       dec,
    input  logic [ADDR_W-1:0] addr,
    input  beat_order_e       order,
    output logic [ADDR_W-1:0] beat_addr,
    output logic [ADDR_W-1:0] beat_addr_nxt,
    output logic              sel_q,
    output logic              sel_nxt,
    output beat_t             cnt_q
);

    localparam int HI_LSB = BEAT_W;

    logic [ADDR_W-1:0] base_q, base_d;
    beat_t             cnt_d;

    always_comb begin
        base_d  = base_q;
        cnt_d   = cnt_q;
        sel_nxt = sel_q;
        if (dec.start) begin
            base_d  = addr;
            cnt_d   = '0;
            sel_nxt = dec.sel;
        end else if (dec.step) begin
            cnt_d = beat_t'(cnt_q + 1'b1);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            base_q <= '0;
            cnt_q  <= '0;
            sel_q  <= 1'b0;
        end else begin
            base_q <= base_d;
            cnt_q  <= cnt_d;
            sel_q  <= sel_nxt;
        end
    end

    assign beat_addr_nxt = {base_d[ADDR_W-1:HI_LSB], beat_low(base_d[BEAT_W-1:0], cnt_d, order)};
    assign beat_addr     = {base_q[ADDR_W-1:HI_LSB], beat_low(base_q[BEAT_W-1:0], cnt_q, order)};

endmodule

// File: rtl/sbsram_array.sv
module sbsram_array #(
    parameter int ADDR_W = 6,
    parameter int BYTES  = 2,
    parameter int BYTE_W = 8
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic [BYTES-1:0]          we,
    input  logic [ADDR_W-1:0]         waddr,
    input  logic [BYTES*BYTE_W-1:0]   wdata,
    input  logic [ADDR_W-1:0]         raddr,
    output logic [BYTES*BYTE_W-1:0]   rdata
);

    localparam int DEPTH = 1 << ADDR_W;

    for (genvar g = 0; g < BYTES; g++) begin : g_lane
        logic [BYTE_W-1:0] lane_mem [DEPTH];

        always_ff @(posedge clk) begin
            if (rst) begin
                for (int i = 0; i < DEPTH; i++) lane_mem[i] <= '0;
            end else if (we[g]) begin
                lane_mem[waddr] <= wdata[g*BYTE_W +: BYTE_W];
            end
        end

        assign rdata[g*BYTE_W +: BYTE_W] = lane_mem[raddr];
    end

endmodule

// File: rtl/sbsram_core.sv
module sbsram_core
    import sbsram_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int BYTES  = 2,
    parameter int BYTE_W = 8
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic [ADDR_W-1:0]       addr_i,
    input  logic [BYTES*BYTE_W-1:0] din_i,
    output logic [BYTES*BYTE_W-1:0] dout_o,
    output logic                    dout_vld_o,
    input  logic                    oe_n_i,
    input  logic                    ce1_n_i,
    input  logic                    ce2_i,
    input  logic                    ce3_n_i,
    input  logic                    pstb_n_i,
    input  logic                    cstb_n_i,
    input  logic                    adv_n_i,
    input  logic                    gw_n_i,
    input  logic                    bwe_n_i,
    input  logic [BYTES-1:0]        bw_n_i,
    input  logic                    mode_i
);

    localparam int DATA_W = BYTES * BYTE_W;

    strobe_dec_t       dec;
    logic [BYTES-1:0]  wmask;
    logic [BYTES-1:0]  we_eff;
    logic [ADDR_W-1:0] beat_addr;
    logic [ADDR_W-1:0] beat_addr_nxt;
    logic              sel_q;
    logic              sel_nxt;
    beat_t             cnt_q;
    logic [DATA_W-1:0] rdata;
    logic              wr_q;
    beat_order_e       order;

    assign order = beat_order_e'(mode_i);

    sbsram_ctl #(.BYTES(BYTES)) u_ctl (
        .pstb_n (pstb_n_i),
        .cstb_n (cstb_n_i),
        .adv_n  (adv_n_i),
        .ce1_n  (ce1_n_i),
        .ce2    (ce2_i),
        .ce3_n  (ce3_n_i),
        .gw_n   (gw_n_i),
        .bwe_n  (bwe_n_i),
        .bw_n   (bw_n_i),
        .dec    (dec),
        .wmask  (wmask)
    );

    sbsram_burst #(.ADDR_W(ADDR_W)) u_burst (
        .clk           (clk),
        .rst           (rst),
        .dec           (dec),
        .addr          (addr_i),
        .order         (order),
        .beat_addr     (beat_addr),
        .beat_addr_nxt (beat_addr_nxt),
        .sel_q         (sel_q),
        .sel_nxt       (sel_nxt),
        .cnt_q         (cnt_q)
    );

    assign we_eff = wmask & {BYTES{sel_nxt}};

    sbsram_array #(.ADDR_W(ADDR_W), .BYTES(BYTES), .BYTE_W(BYTE_W)) u_array (
        .clk   (clk),
        .rst   (rst),
        .we    (we_eff),
        .waddr (beat_addr_nxt),
        .wdata (din_i),
        .raddr (beat_addr),
        .rdata (rdata)
    );

    always_ff @(posedge clk) begin
        if (rst) wr_q <= 1'b0;
        else     wr_q <= |we_eff;
    end

    assign dout_vld_o = sel_q & ~wr_q & ~oe_n_i;
    assign dout_o     = dout_vld_o ? rdata : '0;

endmodule

// File: rtl/sbsram_chk.sv
module sbsram_chk
    import sbsram_pkg::*;
#(
    parameter int ADDR_W = 6
) (
    input logic              clk,
    input logic              rst,
    input logic              pstb_n_i,
    input logic              cstb_n_i,
    input logic              adv_n_i,
    input logic              ce1_n_i,
    input logic              oe_n_i,
    input logic [ADDR_W-1:0] addr_i,
    input logic              dout_vld_o,
    input logic [ADDR_W-1:0] beat_addr,
    input logic              sel_q,
    input beat_t             cnt_q
);

    a_r2_reload: assert property (@(posedge clk) disable iff (rst)
        !cstb_n_i |=> (cnt_q == '0) && (beat_addr == $past(addr_i)));

    a_r3_pstb_reload: assert property (@(posedge clk) disable iff (rst)
        (!pstb_n_i && !ce1_n_i) |=> (cnt_q == '0) && (beat_addr == $past(addr_i)));

    a_r4_step: assert property (@(posedge clk) disable iff (rst)
        (cstb_n_i && pstb_n_i && !adv_n_i) |=> cnt_q == beat_t'($past(cnt_q) + 1'b1));

    a_r4_hold: assert property (@(posedge clk) disable iff (rst)
        (cstb_n_i && pstb_n_i && adv_n_i) |=> $stable(beat_addr) && $stable(sel_q));

    a_r10_pstb_ignored: assert property (@(posedge clk) disable iff (rst)
        (!pstb_n_i && ce1_n_i && cstb_n_i && adv_n_i) |=> $stable(beat_addr) && $stable(sel_q));

    a_r8_oe_blocks: assert property (@(posedge clk) disable iff (rst)
        oe_n_i |-> !dout_vld_o);

    a_r12_desel_quiet: assert property (@(posedge clk) disable iff (rst)
        !sel_q |-> !dout_vld_o);

endmodule

bind sbsram_core sbsram_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .pstb_n_i   (pstb_n_i),
    .cstb_n_i   (cstb_n_i),
    .adv_n_i    (adv_n_i),
    .ce1_n_i    (ce1_n_i),
    .oe_n_i     (oe_n_i),
    .addr_i     (addr_i),
    .dout_vld_o (dout_vld_o),
    .beat_addr  (beat_addr),
    .sel_q      (sel_q),
    .cnt_q      (cnt_q)
);

// File: tb/tb_sbsram_core.sv
`timescale 1ns/1ps
module tb_sbsram_core;

    localparam int AW = 6;
    localparam int NB = 2;
    localparam int DW = 16;
    localparam int DEPTH = 1 << AW;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [AW-1:0] addr_i = '0;
    logic [DW-1:0] din_i = '0;
    logic [DW-1:0] dout_o;
    logic          dout_vld_o;
    logic oe_n_i = 0, ce1_n_i = 0, ce2_i = 1, ce3_n_i = 0;
    logic pstb_n_i = 1, cstb_n_i = 1, adv_n_i = 1, gw_n_i = 1, bwe_n_i = 1;
    logic [NB-1:0] bw_n_i = '1;
    logic mode_i = 0;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // reference model state
    logic [DW-1:0] mmem [DEPTH];
    int  mbase = 0, mcnt = 0;
    bit  msel = 0, mwrq = 0;

    always #5 clk = ~clk;

    sbsram_core #(.ADDR_W(AW), .BYTES(NB), .BYTE_W(8)) dut (
        .clk(clk), .rst(rst), .addr_i(addr_i), .din_i(din_i),
        .dout_o(dout_o), .dout_vld_o(dout_vld_o), .oe_n_i(oe_n_i),
        .ce1_n_i(ce1_n_i), .ce2_i(ce2_i), .ce3_n_i(ce3_n_i),
        .pstb_n_i(pstb_n_i), .cstb_n_i(cstb_n_i), .adv_n_i(adv_n_i),
        .gw_n_i(gw_n_i), .bwe_n_i(bwe_n_i), .bw_n_i(bw_n_i), .mode_i(mode_i)
    );

    function automatic int beat_of(int base, int cnt, bit m);
        int lo = base & 3;
        int nl = m ? (lo ^ cnt) : ((lo + cnt) % 4);
        return (base & ~3) | nl;
    endfunction

    task automatic expect_out(string tag);
        bit            ev = msel && !mwrq && !oe_n_i;
        logic [DW-1:0] ed = ev ? mmem[beat_of(mbase, mcnt, mode_i)] : '0;
        checks++;
        if (dout_vld_o !== ev || dout_o !== ed) begin
            errors++;
            $display("FAIL %s: dout=%h vld=%b expected dout=%h vld=%b", tag, dout_o, dout_vld_o, ed, ev);
        end
    endtask

    task automatic tick(string tag);
        bit pst, st, stp, wrote;
        int a;
        @(posedge clk);
        pst = !pstb_n_i && !ce1_n_i;
        st  = pst || !cstb_n_i;
        stp = cstb_n_i && pstb_n_i && !adv_n_i;
        if (st) begin
            mbase = int'(addr_i); mcnt = 0;
            msel = !ce1_n_i && ce2_i && !ce3_n_i;
        end else if (stp) begin
            mcnt = (mcnt + 1) % 4;
        end
        a = beat_of(mbase, mcnt, mode_i);
        wrote = 0;
        if (!pst && msel) begin
            for (int i = 0; i < NB; i++) begin
                if (!gw_n_i || (!bwe_n_i && !bw_n_i[i])) begin
                    mmem[a][8*i +: 8] = din_i[8*i +: 8];
                    wrote = 1;
                end
            end
        end
        mwrq = wrote;
        #2;
        expect_out(tag);
    endtask

    task automatic idle();
        pstb_n_i = 1; cstb_n_i = 1; adv_n_i = 1; gw_n_i = 1; bwe_n_i = 1;
        bw_n_i = '1; ce1_n_i = 0; ce2_i = 1; ce3_n_i = 0; oe_n_i = 0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        #500us;
        errors++;
        $display("FAIL watchdog: run did not end, expected completion");
        finish_run();
    end

    initial begin
        for (int i = 0; i < DEPTH; i++) mmem[i] = '0;
        idle();
        repeat (3) @(posedge clk);
        #2;
        expect_out("R1 reset held");
        rst = 0;
        tick("R1 after reset");

        // R11/R6: linear write burst from address 6 (beats 6,7,4,5)
        mode_i = 0; cstb_n_i = 0; addr_i = 6; gw_n_i = 0; din_i = 16'hA000;
        tick("R11 global write start");
        cstb_n_i = 1; adv_n_i = 0;
        for (int k = 1; k < 4; k++) begin
            din_i = 16'hA000 + 16'(k);
            tick("R6 linear write beat");
        end
        idle();
        tick("R7 idle after write");

        // R7/R6/R4: linear read burst and wrap
        cstb_n_i = 0; addr_i = 6;
        tick("R7 flow-through first beat");
        cstb_n_i = 1; adv_n_i = 0;
        for (int k = 0; k < 4; k++) tick("R4 linear read and wrap");
        adv_n_i = 1;
        tick("R4 hold without advance");
        tick("R4 hold again");

        // R5/R10: interleaved read from 5 via processor strobe, write controls ignored
        mode_i = 1; pstb_n_i = 0; addr_i = 5; gw_n_i = 0; din_i = 16'hDEAD;
        tick("R10 pstb start is a read");
        idle(); adv_n_i = 0;
        for (int k = 0; k < 4; k++) tick("R5 xor order beat");
        idle();

        // R11: byte writes
        mode_i = 0; cstb_n_i = 0; addr_i = 8; bwe_n_i = 0; bw_n_i = 2'b10; din_i = 16'h1234;
        tick("R11 byte0 write");
        idle();
        tick("R11 byte0 readback");
        bwe_n_i = 0; bw_n_i = 2'b01; din_i = 16'hABCD;
        tick("R11 byte1 write");
        idle();
        tick("R11 merged readback");
        bwe_n_i = 1; bw_n_i = 2'b00; din_i = 16'hFFFF;
        tick("R11 strobes without enable");
        idle();
        tick("R11 no change readback");

        // R9/R12: deselected write has no effect
        cstb_n_i = 0; addr_i = 9; ce2_i = 0; gw_n_i = 0; din_i = 16'hFFFF;
        tick("R12 deselected write");
        idle();
        tick("R9 still deselected");
        cstb_n_i = 0; addr_i = 9; ce3_n_i = 1;
        tick("R9 ce3 high deselects");
        idle(); cstb_n_i = 0; addr_i = 9;
        tick("R12 readback unchanged");
        gw_n_i = 0; din_i = 16'h5555; cstb_n_i = 1;
        tick("R11 write at held address");
        idle();
        tick("R11 readback 5555");

        // R10: processor strobe with ce1 high ignored
        pstb_n_i = 0; ce1_n_i = 1; addr_i = 6;
        tick("R10 pstb ignored");
        idle();
        tick("R10 address kept");

        // R2/R3: restart mid-burst, with advance low on the strobe edge
        cstb_n_i = 0; addr_i = 4;
        tick("R2 start");
        cstb_n_i = 1; adv_n_i = 0;
        tick("R3 one advance");
        cstb_n_i = 0; addr_i = 9;
        tick("R3 restart mid-burst");
        cstb_n_i = 1; adv_n_i = 1;
        tick("R2 kept address");

        // R8: output enable without a clock edge
        #1; oe_n_i = 1; #1;
        expect_out("R8 oe high blanks");
        oe_n_i = 0; #1;
        expect_out("R8 oe low restores");

        // random phases, one per order
        for (int ph = 0; ph < 2; ph++) begin
            mode_i = ph[0];
            for (int n = 0; n < 600; n++) begin
                pstb_n_i = ($urandom % 4) != 0;
                cstb_n_i = ($urandom % 4) != 0;
                adv_n_i  = ($urandom % 2) != 0;
                gw_n_i   = ($urandom % 4) != 0;
                bwe_n_i  = ($urandom % 2) != 0;
                bw_n_i   = NB'($urandom);
                ce1_n_i  = ($urandom % 8) == 0;
                ce2_i    = ($urandom % 8) != 0;
                ce3_n_i  = ($urandom % 8) == 0;
                oe_n_i   = ($urandom % 6) == 0;
                addr_i   = AW'($urandom);
                din_i    = DW'($urandom);
                tick("R7 random traffic");
            end
        end
        idle();
        tick("R7 final");
        finish_run();
    end

endmodule